// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block keeps the interrupt state for a group of timer channels. It holds one 32-bit word that carries an enable bit and a pending-status bit for each channel, and it drives one interrupt line per channel. Each channel's timer logic delivers a one-cycle expiry pulse. The pulse always marks the channel as pending. It also raises that channel's interrupt line, but only when the channel's enable bit is already set.

Software reads the whole word on a readback port. It writes the word through a single-cycle write strobe. A write replaces all the enable bits at once. In the same write, every status bit written as one is cleared, and clearing a status bit drops that channel's interrupt line. Once raised, an interrupt line stays up until its status bit is cleared. It does not follow status AND enable continuously. The counting logic of the timers is outside this block.

Top module: `timer_irq_stat`

## Requirements
- R1: The word layout is fixed. Bit x (x in 0..NCH-1) is channel x's enable. Bit NCH+x is channel x's status. With the default NCH=5, enables sit in [4:0] and status flags sit in [9:5].
- R2: An expiry pulse on channel x sets status bit NCH+x in the next cycle, whether or not the channel's enable is set.
- R3: An expiry on channel x raises irq[x] in the next cycle only if enable bit x is set before that cycle's write takes effect. An expiry on a disabled channel leaves irq[x] as it was.
- R4: A write replaces every enable bit with wr_data[NCH-1:0] in the next cycle.
- R5: On a write, each status bit whose wr_data bit is 1 is cleared. Each status bit whose wr_data bit is 0 keeps its value.
- R6: irq[x] falls when, and only when, a write takes status bit NCH+x from 1 to 0. Clearing or setting the enable neither lowers nor raises a line.
- R7: Synchronous active-high reset clears the whole word and every interrupt line.
- R8: If an expiry and a clearing write hit the same channel in the same cycle, the status bit ends up set. The line is then raised if the channel was enabled, and otherwise keeps its value.
- R9: Bits [31:2*NCH] always read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word, one cycle per write |
| wr_data | input | 32 | Write value: enables at [NCH-1:0], write-one-to-clear status at [2*NCH-1:NCH] |
| expire | input | NCH | Per-channel expiry pulses from the timers |
| rd_data | output | 32 | Current word: enables, status, zero upper bits |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The checker treats `expire` and `wr_en` as free inputs that may arrive in any cycle, in any combination, and together. It assumes only that their values are stable at each rising edge. The checker asserts two invariants across all traffic: a line is never up without its status bit, and every rise or fall of a line is traced back to an enabled expiry or a clearing write in the previous cycle. The bench drives inputs on the falling edge, so every input combination presented to the design is legal. It sweeps every enable pattern against every expiry pattern, and it issues partial clears and collisions on purpose to reach the same-cycle cases.

// File: rtl/timer_irq_stat_pkg.sv
package timer_irq_stat_pkg;

    localparam int unsigned REG_W = 32;

    // Per-channel update request built from the word-level inputs.
    typedef struct packed {
        logic set;   // expiry seen this cycle
        logic arm;   // expiry seen while enabled: raise the line
        logic clr;   // write-one-to-clear on this channel's status
    } ch_evt_t;

    function automatic ch_evt_t make_evt(input logic expiry,
                                         input logic enabled,
                                         input logic wr_stb,
                                         input logic clr_bit);
        ch_evt_t e;
        e.set = expiry;
        e.arm = expiry & enabled;
        e.clr = wr_stb & clr_bit;
        return e;
    endfunction

endpackage

// File: rtl/timer_irq_stat_enable.sv
module timer_irq_stat_enable #(
    parameter int unsigned NCH = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_en_bits,
    output logic [NCH-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_en_bits;
        end
    end
endmodule

// File: rtl/timer_irq_stat_chan.sv
module timer_irq_stat_chan
    import timer_irq_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_evt_t evt,
    output logic    status_q,
    output logic    irq_q
);
    logic status_d;
    logic irq_d;
    logic drop;

    // A clear that really takes the flag down; a same-cycle set wins.
    assign drop = evt.clr & ~evt.set & status_q;

    always_comb begin
        status_d = status_q;
        if (evt.clr) status_d = 1'b0;
        if (evt.set) status_d = 1'b1;

        irq_d = irq_q;
        if (drop)    irq_d = 1'b0;
        if (evt.arm) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= irq_d;
        end
    end
endmodule

// File: rtl/timer_irq_stat_readback.sv
module timer_irq_stat_readback
    import timer_irq_stat_pkg::*;
#(
    parameter int unsigned NCH = 5
) (
    input  logic [NCH-1:0]   en,
    input  logic [NCH-1:0]   status,
    output logic [REG_W-1:0] word
);
    localparam int unsigned PAD_W = REG_W - 2 * NCH;

    assign word = {{PAD_W{1'b0}}, status, en};
endmodule

// File: rtl/timer_irq_stat.sv
module timer_irq_stat
    import timer_irq_stat_pkg::*;
#(
    parameter int unsigned NCH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NCH-1:0]   expire,
    output logic [REG_W-1:0] rd_data,
    output logic [NCH-1:0]   irq
);
    localparam int unsigned ST_LO = NCH;
    localparam int unsigned ST_HI = 2 * NCH - 1;

    logic [NCH-1:0] en_q;
    logic [NCH-1:0] status_q;
    logic [NCH-1:0] clr_bits;
    logic           unused_hi;

    assign clr_bits  = wr_data[ST_HI:ST_LO];
    assign unused_hi = ^wr_data[REG_W-1:ST_HI+1];

    timer_irq_stat_enable #(.NCH(NCH)) u_enable (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_en_bits (wr_data[NCH-1:0]),
        .en_q       (en_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_evt_t evt;
        assign evt = make_evt(expire[g], en_q[g], wr_en, clr_bits[g]);

        timer_irq_stat_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .status_q (status_q[g]),
            .irq_q    (irq[g])
        );
    end

    timer_irq_stat_readback #(.NCH(NCH)) u_readback (
        .en     (en_q),
        .status (status_q),
        .word   (rd_data)
    );
endmodule

// File: rtl/timer_irq_stat_chk.sv
module timer_irq_stat_chk
    import timer_irq_stat_pkg::*;
#(
    parameter int unsigned NCH = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [NCH-1:0]   expire,
    input logic [REG_W-1:0] rd_data,
    input logic [NCH-1:0]   irq
);
    logic [NCH-1:0] en_v;
    logic [NCH-1:0] st_v;
    logic [NCH-1:0] clr_v;
    assign en_v  = rd_data[NCH-1:0];
    assign st_v  = rd_data[2*NCH-1:NCH];
    assign clr_v = wr_data[2*NCH-1:NCH];

    // R2
    expiry_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (expire != '0) |=> ((st_v & $past(expire)) == $past(expire)));

    // R3
    enabled_expiry_raises_chk: assert property (@(posedge clk) disable iff (rst)
        ((expire & en_v) != '0) |=> ((irq & $past(expire & en_v)) == $past(expire & en_v)));

    // R4
    enable_replaced_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (en_v == $past(wr_data[NCH-1:0])));

    // R5
    clear_ones_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((st_v & $past(clr_v & ~expire)) == '0));

    // R5
    keep_zeros_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((st_v & $past(st_v & ~clr_v)) == $past(st_v & ~clr_v)));

    // R6
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~st_v) == '0));

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (irq & ~$past(irq) & ~$past(expire & en_v)) == '0);

    // R6
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (~irq & $past(irq)) != '0 |-> $past(wr_en));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((expire & clr_v) != '0)) |=> ((st_v & $past(expire & clr_v)) == $past(expire & clr_v)));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:2*NCH] == '0);
endmodule

bind timer_irq_stat timer_irq_stat_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .expire  (expire),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/timer_irq_stat_tb.sv
module timer_irq_stat_tb;
    localparam int NCH = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [NCH-1:0]  expire = '0;
    logic [31:0]     rd_data;
    logic [NCH-1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [NCH-1:0] en_m = '0;
    logic [NCH-1:0] st_m = '0;
    logic [NCH-1:0] irq_m = '0;

    always #2.5 clk = ~clk;

    timer_irq_stat #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .expire(expire), .rd_data(rd_data), .irq(irq)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive on falling edge, update model, compare on next falling edge.
    task automatic step(input string tag, input logic we, input logic [31:0] wd, input logic [NCH-1:0] ex);
        logic [NCH-1:0] clr;
        logic [NCH-1:0] n_st;
        logic [NCH-1:0] n_irq;
        wr_en   = we;
        wr_data = wd;
        expire  = ex;
        clr   = we ? wd[2*NCH-1:NCH] : '0;
        n_st  = (st_m & ~clr) | ex;
        n_irq = (irq_m & ~(st_m & clr & ~ex)) | (ex & en_m);
        if (we) en_m = wd[NCH-1:0];
        st_m  = n_st;
        irq_m = n_irq;
        @(negedge clk);
        check32({tag, " word"}, rd_data, {22'd0, st_m, en_m});
        check32({tag, " irq"}, {27'd0, irq}, {27'd0, irq_m});
    endtask

    function automatic logic [31:0] wr_word(input logic [NCH-1:0] en, input logic [NCH-1:0] clr);
        return {22'd0, clr, en};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: reset state
        check32("R7 reset word", rd_data, 32'd0);
        check32("R7 reset irq", {27'd0, irq}, 32'd0);

        // R1: fixed layout, enables at bits 0 and 2, channel 3 status at bit 8
        step("R1 layout", 1'b1, wr_word(5'b00101, 5'b0), '0);
        step("R1 layout", 1'b0, '0, 5'b01000);
        check32("R1 exact word", rd_data, 32'h0000_0105);

        // R2/R3: every enable pattern against every expiry pattern
        for (int e = 0; e < 32; e++) begin
            step("R4 set enables", 1'b1, wr_word(e[4:0], 5'h1F), '0);
            for (int x = 0; x < 32; x++) begin
                step("R2 R3 expiry", 1'b0, '0, x[4:0]);
                step("R5 R6 clear all", 1'b1, wr_word(e[4:0], 5'h1F), '0);
            end
        end

        // R5: partial clears leave zero-written status bits
        step("R4 enable all", 1'b1, wr_word(5'h1F, 5'h0), '0);
        for (int c = 0; c < 32; c++) begin
            step("R2 arm all", 1'b0, '0, 5'h1F);
            step("R5 partial clear", 1'b1, wr_word(5'h1F, c[4:0]), '0);
            step("R5 clear rest", 1'b1, wr_word(5'h1F, 5'h1F), '0);
        end

        // R6: disabling keeps a raised line; enabling later raises nothing
        step("R3 raise", 1'b0, '0, 5'b10010);
        step("R6 disable keeps irq", 1'b1, wr_word(5'h0, 5'h0), '0);
        step("R6 hold", 1'b0, '0, 5'b00100);
        step("R6 enable no raise", 1'b1, wr_word(5'h1F, 5'h0), '0);
        step("R6 clear drops irq", 1'b1, wr_word(5'h1F, 5'h1F), '0);

        // R8: collision of expiry and clear, enabled and disabled
        for (int k = 0; k < 32; k++) begin
            step("R4 enable pattern", 1'b1, wr_word(k[4:0], 5'h0), '0);
            step("R8 collide", 1'b1, wr_word(k[4:0], 5'h1F), 5'h1F);
            step("R8 collide again", 1'b1, wr_word(~k[4:0], 5'h1F), k[4:0]);
            step("R5 cleanup", 1'b1, wr_word(5'h0, 5'h1F), '0);
        end

        // R9: upper bits ignored on write, read zero
        step("R9 upper write", 1'b1, 32'hFFFF_FC00 | wr_word(5'b01010, 5'h0), 5'b00001);
        step("R9 upper ones", 1'b1, 32'hFFFF_FFFF, '0);
        check32("R9 upper bits", {rd_data[31:10], 10'd0}, 32'd0);

        // R7: reset in mid-traffic
        step("R3 raise before reset", 1'b1, wr_word(5'h1F, 5'h0), '0);
        step("R3 raise before reset", 1'b0, '0, 5'h1F);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        en_m = '0; st_m = '0; irq_m = '0;
        check32("R7 reset again word", rd_data, 32'd0);
        check32("R7 reset again irq", {27'd0, irq}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule